// File: doc/BRIEF.md
# Multi-Source Interrupt Vector Controller

This block gathers level requests from seven interrupt causes and turns them into six level lines that feed a downstream interrupt source controller. Each cause keeps a status bit. Six vector registers decide where each cause lands. Each vector register holds a destination server, a priority and a line number, and reports a pending flag derived from activity and masking. Two causes share one vector register. Their output line is only dropped when both of them have gone quiet.

Requests come in one per cycle as an index with a level. Software programs the vectors, reads them back, reads the status and control words and sets an interrupt-number base through a word-wide register port. Every vector write whose line number is valid produces a one-cycle programming record for the downstream controller. The record carries the line, the priority and the server number scaled down by four. Each output line also reports its global interrupt number, which is the base plus the line index.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every vector register reads priority 0xFF with line number equal to its own address (0 to 5), server 0 and pending 0. All lines are low, all status and control bits are 0, and the error flag is 0.
- R2: Vector registers sit at addresses 0 to 5. The server is in bits 55:40, the priority in bits 39:32, the line number in bits 31:29 and the pending flag in bit 24. All other bits read 0. A write loads only server, priority and line number and leaves the pending flag as it was.
- R3: A request with level 1 sets the cause's status bit and raises the line named by its vector's line number, whatever the priority.
- R4: Causes 2 to 5 use vectors 1 to 4 and status bits 36, 35, 34 and 33 of the status word (address 7). Cause 6 uses vector 5 and bit 32. A request with level 0 clears the bit and lowers the line.
- R5: Causes 0 and 1 share vector 0 and keep status in bits 47 and 46 of the control word (address 6). When either one drops, the line stays high and counts as active while the other bit is still set. It falls only when both bits are clear.
- R6: On every accepted request, the target vector's pending flag is rewritten as (cause active) AND NOT (priority == 0xFF).
- R7: The cycle after a vector write with line number 0 to 5, prog_valid_o is high with that line number, server bits 55:42 and the priority. A write with line number 6 or 7 is stored but raises no programming record, and requests through that vector drive no line.
- R8: Address 8 stores a 19-bit base from bits 63:45 and reads it back in the same place. Line i reports base + i on irq_num_o[20*i +: 20].
- R9: A request with cause index 7 changes no status, control or line state, and sets the error flag, which then stays set until reset.
- R10: Writes to the status word and the control word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request update is present this cycle |
| req_idx_i | input | 3 | Cause index (0 to 6 valid) |
| req_level_i | input | 1 | New level of the cause |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational from address |
| irq_o | output | 6 | Level lines toward the source controller |
| irq_num_o | output | 120 | Global interrupt number per line, 20 bits each |
| prog_valid_o | output | 1 | Downstream entry programming record valid |
| prog_src_o | output | 3 | Line number being programmed |
| prog_server_o | output | 14 | Server number, written server shifted right by 2 |
| prog_prio_o | output | 8 | Priority being programmed |
| err_o | output | 1 | Sticky unsupported-cause flag |

## Verification
Each state change is registered at the clock edge that samples the request or write. Status, control, pending, line levels, the error flag and the programming record are therefore all due one cycle after the stimulus. The record lasts for exactly that one cycle. Reads and the per-line interrupt numbers are combinational, so they are due as soon as the address is applied. The bench drives at the falling edge and lets one rising edge pass. It then checks lines and the record at the next falling edge and reads registers a moment later, so every value is sampled in the cycle it becomes due.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_VEC    = 6;
  localparam int NUM_CAUSE  = 7;
  localparam int SRV_W      = 16;
  localparam int PRIO_W     = 8;
  localparam int SRC_W      = 3;
  localparam int BASE_W     = 19;
  localparam int NUM_W      = BASE_W + 1;
  localparam int DATA_W     = 64;
  localparam int ADDR_W     = 4;
  localparam int IDX_W      = 3;
  localparam int STAT_N     = NUM_CAUSE - 2;
  localparam int SRV_LSB    = 40;
  localparam int PRIO_LSB   = 32;
  localparam int SRC_LSB    = 29;
  localparam int PEND_BIT   = 24;
  localparam int CTRL_LSB   = 46;
  localparam int STAT_LSB   = 32;
  localparam int BASE_LSB   = DATA_W - BASE_W;
  localparam int SRV_SHIFT  = 2;
  localparam int PSRV_W     = SRV_W - SRV_SHIFT;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_VEC);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_VEC + 1);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(NUM_VEC + 2);
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  // causes 0 and 1 share vector 0, cause k>=2 owns vector k-1
  function automatic logic [IDX_W-1:0] cause_vec(input logic [IDX_W-1:0] c);
    return (c < IDX_W'(2)) ? '0 : c - IDX_W'(1);
  endfunction
endpackage

// File: rtl/ivc_cause_track.sv
module ivc_cause_track
  import ivc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              req_level_i,
  output logic [1:0]        ctrl_o,
  output logic [STAT_N-1:0] stat_o,
  output logic              err_o,
  output logic              upd_valid_o,
  output logic [IDX_W-1:0]  upd_vec_o,
  output logic              upd_active_o
);
  logic [1:0]        ctrl_q;
  logic [STAT_N-1:0] stat_q;
  logic              err_q;
  logic              cause_ok;
  logic              shared;
  logic              other_on;

  always_comb begin
    cause_ok = req_idx_i < IDX_W'(NUM_CAUSE);
    shared   = req_idx_i < IDX_W'(2);
    // ctrl_q[1] belongs to cause 0, ctrl_q[0] to cause 1
    other_on = (req_idx_i == '0) ? ctrl_q[0] : ctrl_q[1];
  end

  assign upd_valid_o  = req_valid_i && cause_ok;
  assign upd_vec_o    = cause_vec(req_idx_i);
  assign upd_active_o = req_level_i || (shared && other_on);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      err_q  <= 1'b0;
    end else if (req_valid_i) begin
      if (!cause_ok) begin
        err_q <= 1'b1;
      end else if (shared) begin
        if (req_idx_i == '0) ctrl_q[1] <= req_level_i;
        else                 ctrl_q[0] <= req_level_i;
      end else begin
        stat_q[IDX_W'(NUM_CAUSE - 1) - req_idx_i] <= req_level_i;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign err_o  = err_q;
endmodule

// File: rtl/ivc_vector_bank.sv
module ivc_vector_bank
  import ivc_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_we_i,
  input  logic [ADDR_W-1:0]                 reg_addr_i,
  input  logic [DATA_W-1:0]                 reg_wdata_i,
  input  logic                              upd_valid_i,
  input  logic [IDX_W-1:0]                  upd_vec_i,
  input  logic                              upd_active_i,
  output logic [NUM_VEC-1:0][SRV_W-1:0]     srv_o,
  output logic [NUM_VEC-1:0][PRIO_W-1:0]    prio_o,
  output logic [NUM_VEC-1:0][SRC_W-1:0]     src_o,
  output logic [NUM_VEC-1:0]                pend_o,
  output logic                              prog_valid_o,
  output logic [SRC_W-1:0]                  prog_src_o,
  output logic [PSRV_W-1:0]                 prog_server_o,
  output logic [PRIO_W-1:0]                 prog_prio_o
);
  logic [SRV_W-1:0]  w_srv;
  logic [PRIO_W-1:0] w_prio;
  logic [SRC_W-1:0]  w_src;
  logic              w_vec;

  assign w_srv  = reg_wdata_i[SRV_LSB  +: SRV_W];
  assign w_prio = reg_wdata_i[PRIO_LSB +: PRIO_W];
  assign w_src  = reg_wdata_i[SRC_LSB  +: SRC_W];
  assign w_vec  = reg_we_i && (reg_addr_i < ADDR_W'(NUM_VEC));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [SRV_W-1:0]  srv_q;
    logic [PRIO_W-1:0] prio_q;
    logic [SRC_W-1:0]  src_q;
    logic              pend_q;
    logic              hit_wr;
    logic              hit_upd;

    assign hit_wr  = reg_we_i && (reg_addr_i == ADDR_W'(v));
    assign hit_upd = upd_valid_i && (upd_vec_i == IDX_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        srv_q  <= '0;
        prio_q <= PRIO_MASKED;
        src_q  <= SRC_W'(v);
        pend_q <= 1'b0;
      end else begin
        if (hit_wr) begin
          srv_q  <= w_srv;
          prio_q <= w_prio;
          src_q  <= w_src;
        end
        if (hit_upd) pend_q <= upd_active_i && (prio_q != PRIO_MASKED);
      end
    end

    assign srv_o[v]  = srv_q;
    assign prio_o[v] = prio_q;
    assign src_o[v]  = src_q;
    assign pend_o[v] = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_valid_o  <= 1'b0;
      prog_src_o    <= '0;
      prog_server_o <= '0;
      prog_prio_o   <= '0;
    end else begin
      prog_valid_o <= w_vec && (w_src < SRC_W'(NUM_VEC));
      if (w_vec) begin
        prog_src_o    <= w_src;
        prog_server_o <= w_srv[SRV_W-1:SRV_SHIFT];
        prog_prio_o   <= w_prio;
      end
    end
  end
endmodule

// File: rtl/ivc_line_drv.sv
module ivc_line_drv
  import ivc_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_valid_i,
  input  logic [IDX_W-1:0]              upd_vec_i,
  input  logic                          upd_active_i,
  input  logic [NUM_VEC-1:0][SRC_W-1:0] src_i,
  input  logic                          base_we_i,
  input  logic [BASE_W-1:0]             base_wdata_i,
  output logic [BASE_W-1:0]             base_o,
  output logic [NUM_VEC-1:0]            irq_o,
  output logic [NUM_VEC*NUM_W-1:0]      irq_num_o
);
  logic [NUM_VEC-1:0] irq_q;
  logic [BASE_W-1:0]  base_q;
  logic [SRC_W-1:0]   sel_src;
  logic               sel_ok;

  always_comb begin
    sel_src = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (upd_vec_i == IDX_W'(v)) sel_src = src_i[v];
    end
    sel_ok = upd_valid_i && (sel_src < SRC_W'(NUM_VEC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      base_q <= '0;
    end else begin
      if (sel_ok) irq_q[sel_src] <= upd_active_i;
      if (base_we_i) base_q <= base_wdata_i;
    end
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_num
    assign irq_num_o[i*NUM_W +: NUM_W] = NUM_W'(base_q) + NUM_W'(i);
  end

  assign irq_o  = irq_q;
  assign base_o = base_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [IDX_W-1:0]             req_idx_i,
  input  logic                         req_level_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic [NUM_VEC-1:0]           irq_o,
  output logic [NUM_VEC*NUM_W-1:0]     irq_num_o,
  output logic                         prog_valid_o,
  output logic [SRC_W-1:0]             prog_src_o,
  output logic [PSRV_W-1:0]            prog_server_o,
  output logic [PRIO_W-1:0]            prog_prio_o,
  output logic                         err_o
);
  logic [1:0]                      ctrl_w;
  logic [STAT_N-1:0]               stat_w;
  logic                            upd_valid;
  logic [IDX_W-1:0]                upd_vec;
  logic                            upd_active;
  logic [NUM_VEC-1:0][SRV_W-1:0]   vec_srv_w;
  logic [NUM_VEC-1:0][PRIO_W-1:0]  vec_prio_w;
  logic [NUM_VEC-1:0][SRC_W-1:0]   vec_src_w;
  logic [NUM_VEC-1:0]              vec_pend_w;
  logic [BASE_W-1:0]               base_w;

  ivc_cause_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_idx_i    (req_idx_i),
    .req_level_i  (req_level_i),
    .ctrl_o       (ctrl_w),
    .stat_o       (stat_w),
    .err_o        (err_o),
    .upd_valid_o  (upd_valid),
    .upd_vec_o    (upd_vec),
    .upd_active_o (upd_active)
  );

  ivc_vector_bank u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .upd_valid_i   (upd_valid),
    .upd_vec_i     (upd_vec),
    .upd_active_i  (upd_active),
    .srv_o         (vec_srv_w),
    .prio_o        (vec_prio_w),
    .src_o         (vec_src_w),
    .pend_o        (vec_pend_w),
    .prog_valid_o  (prog_valid_o),
    .prog_src_o    (prog_src_o),
    .prog_server_o (prog_server_o),
    .prog_prio_o   (prog_prio_o)
  );

  ivc_line_drv u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_valid_i  (upd_valid),
    .upd_vec_i    (upd_vec),
    .upd_active_i (upd_active),
    .src_i        (vec_src_w),
    .base_we_i    (reg_we_i && (reg_addr_i == A_BASE)),
    .base_wdata_i (reg_wdata_i[BASE_LSB +: BASE_W]),
    .base_o       (base_w),
    .irq_o        (irq_o),
    .irq_num_o    (irq_num_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < ADDR_W'(NUM_VEC)) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (reg_addr_i == ADDR_W'(v)) begin
          reg_rdata_o[SRV_LSB  +: SRV_W]  = vec_srv_w[v];
          reg_rdata_o[PRIO_LSB +: PRIO_W] = vec_prio_w[v];
          reg_rdata_o[SRC_LSB  +: SRC_W]  = vec_src_w[v];
          reg_rdata_o[PEND_BIT]           = vec_pend_w[v];
        end
      end
    end else if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[CTRL_LSB +: 2] = ctrl_w;
    end else if (reg_addr_i == A_STAT) begin
      reg_rdata_o[STAT_LSB +: STAT_N] = stat_w;
    end else if (reg_addr_i == A_BASE) begin
      reg_rdata_o[BASE_LSB +: BASE_W] = base_w;
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_valid_i,
  input logic [IDX_W-1:0]              req_idx_i,
  input logic                          req_level_i,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [NUM_VEC-1:0]            irq_o,
  input logic                          err_o,
  input logic                          prog_valid_o,
  input logic [SRC_W-1:0]              prog_src_o,
  input logic [NUM_VEC-1:0][SRC_W-1:0] vec_src,
  input logic [NUM_VEC-1:0][PRIO_W-1:0] vec_prio,
  input logic [NUM_VEC-1:0]            vec_pend,
  input logic [1:0]                    ctrl_bits
);
  logic [IDX_W-1:0]  vix;
  logic [SRC_W-1:0]  line_sel;
  logic [PRIO_W-1:0] prio_sel;
  logic              idx_ok;

  always_comb begin
    vix      = cause_vec(req_idx_i);
    idx_ok   = req_idx_i < IDX_W'(NUM_CAUSE);
    line_sel = '0;
    prio_sel = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (vix == IDX_W'(v)) begin
        line_sel = vec_src[v];
        prio_sel = vec_prio[v];
      end
    end
  end

  a_r3_raise_any_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_level_i && idx_ok && line_sel < SRC_W'(NUM_VEC))
      |=> irq_o[$past(line_sel)]);

  a_r5_shared_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_idx_i == '0 && !req_level_i && ctrl_bits[0]
      && line_sel < SRC_W'(NUM_VEC)) |=> irq_o[$past(line_sel)]);

  a_r6_masked_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && idx_ok && prio_sel == PRIO_MASKED) |=> !vec_pend[$past(vix)]);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r7_prog_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_valid_o |-> ($past(reg_we_i) && $past(reg_addr_i) < ADDR_W'(NUM_VEC)
      && prog_src_o < SRC_W'(NUM_VEC)));
endmodule

bind irq_vector_ctrl ivc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_idx_i    (req_idx_i),
  .req_level_i  (req_level_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .irq_o        (irq_o),
  .err_o        (err_o),
  .prog_valid_o (prog_valid_o),
  .prog_src_o   (prog_src_o),
  .vec_src      (vec_src_w),
  .vec_prio     (vec_prio_w),
  .vec_pend     (vec_pend_w),
  .ctrl_bits    (ctrl_w)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 9;
  // {cause[3], level, lines[6], status 36..32, control 47..46, err}
  localparam logic [17:0] TBL [NT] = '{
    {3'd2, 1'b1, 6'b000010, 5'b10000, 2'b00, 1'b0},
    {3'd6, 1'b1, 6'b100010, 5'b10001, 2'b00, 1'b0},
    {3'd0, 1'b1, 6'b100011, 5'b10001, 2'b10, 1'b0},
    {3'd1, 1'b1, 6'b100011, 5'b10001, 2'b11, 1'b0},
    {3'd0, 1'b0, 6'b100011, 5'b10001, 2'b01, 1'b0},
    {3'd1, 1'b0, 6'b100010, 5'b10001, 2'b00, 1'b0},
    {3'd2, 1'b0, 6'b100000, 5'b00001, 2'b00, 1'b0},
    {3'd7, 1'b1, 6'b100000, 5'b00001, 2'b00, 1'b1},
    {3'd6, 1'b0, 6'b000000, 5'b00000, 2'b00, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [2:0]   req_idx_i = '0;
  logic         req_level_i = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [63:0]  reg_wdata_i = '0;
  logic [63:0]  reg_rdata_o;
  logic [5:0]   irq_o;
  logic [119:0] irq_num_o;
  logic         prog_valid_o;
  logic [2:0]   prog_src_o;
  logic [13:0]  prog_server_o;
  logic [7:0]   prog_prio_o;
  logic         err_o;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_idx_i(req_idx_i), .req_level_i(req_level_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .irq_num_o(irq_num_o),
    .prog_valid_o(prog_valid_o), .prog_src_o(prog_src_o),
    .prog_server_o(prog_server_o), .prog_prio_o(prog_prio_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic req(input logic [2:0] idx, input logic lvl);
    req_valid_i = 1'b1; req_idx_i = idx; req_level_i = lvl;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [63:0] vword(input logic [15:0] s, input logic [7:0] p,
                                        input logic [2:0] n, input logic pd);
    return {8'h00, s, p, n, 4'h0, pd, 24'h0};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lines", 64'(irq_o), 64'h0);
    chk("R1 err", 64'(err_o), 64'h0);
    for (int v = 0; v < 6; v++) begin
      rd(4'(v), d);
      chk("R1 vector", d, vword(16'h0, 8'hFF, 3'(v), 1'b0));
    end
    rd(4'd7, d); chk("R1 status", d, 64'h0);
    rd(4'd6, d); chk("R1 control", d, 64'h0);

    // table walk: R3 R4 R5 R9
    for (int i = 0; i < NT; i++) begin
      req(TBL[i][17:15], TBL[i][14]);
      chk("R3/R4/R5 lines", 64'(irq_o), 64'(TBL[i][13:8]));
      chk("R9 err", 64'(err_o), 64'(TBL[i][0]));
      rd(4'd7, d); chk("R4 status", d, 64'(TBL[i][7:3]) << 32);
      rd(4'd6, d); chk("R5 control", d, 64'(TBL[i][2:1]) << 46);
    end

    // R2 / R7 write vector 3 with stray bits
    wr(4'd3, vword(16'h1234, 8'h05, 3'd3, 1'b1) | 64'h8000_0000_0000_0001);
    chk("R7 prog valid", 64'(prog_valid_o), 64'h1);
    chk("R7 prog src", 64'(prog_src_o), 64'h3);
    chk("R7 prog server", 64'(prog_server_o), 64'h048D);
    chk("R7 prog prio", 64'(prog_prio_o), 64'h05);
    rd(4'd3, d); chk("R2 readback", d, vword(16'h1234, 8'h05, 3'd3, 1'b0));
    @(negedge clk);
    chk("R7 prog one cycle", 64'(prog_valid_o), 64'h0);

    // R6 pending when unmasked
    req(3'd4, 1'b1);
    chk("R3 line3", 64'(irq_o), 64'h08);
    rd(4'd3, d); chk("R6 pending set", d, vword(16'h1234, 8'h05, 3'd3, 1'b1));
    // R2 write keeps pending
    wr(4'd3, vword(16'h1234, 8'hFF, 3'd3, 1'b0));
    rd(4'd3, d); chk("R2 pending kept", d, vword(16'h1234, 8'hFF, 3'd3, 1'b1));
    req(3'd4, 1'b0);
    chk("R4 line3 low", 64'(irq_o), 64'h00);
    rd(4'd3, d); chk("R6 pending clear", d, vword(16'h1234, 8'hFF, 3'd3, 1'b0));
    req(3'd4, 1'b1);
    chk("R3 masked raises", 64'(irq_o), 64'h08);
    rd(4'd3, d); chk("R6 masked no pending", d, vword(16'h1234, 8'hFF, 3'd3, 1'b0));

    // R7 out-of-range line number
    wr(4'd2, vword(16'h0040, 8'h01, 3'd6, 1'b0));
    chk("R7 no prog", 64'(prog_valid_o), 64'h0);
    rd(4'd2, d); chk("R7 stored", d, vword(16'h0040, 8'h01, 3'd6, 1'b0));
    req(3'd3, 1'b1);
    chk("R7 no line", 64'(irq_o), 64'h08);
    rd(4'd7, d); chk("R4 status bit35", d, 64'h0000_000C_0000_0000);

    // R8 base
    wr(4'd8, 64'(19'h12345) << 45 | 64'h1);
    rd(4'd8, d); chk("R8 base readback", d, 64'(19'h12345) << 45);
    chk("R8 num line0", 64'(irq_num_o[19:0]), 64'h12345);
    chk("R8 num line5", 64'(irq_num_o[119:100]), 64'h1234A);

    // R10 read-only words
    wr(4'd7, '1);
    wr(4'd6, '1);
    rd(4'd7, d); chk("R10 status", d, 64'h0000_000C_0000_0000);
    rd(4'd6, d); chk("R10 control", d, 64'h0);
    chk("R9 err still", 64'(err_o), 64'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule